// File: doc/BRIEF.md
# SDRAM Open-Bank Tracker with Next-Bank Lookahead

This block sits in front of the command scheduler of a pipelined SDRAM controller. For each access it is handed, it splits the linear word address into row, bank and column fields. It then looks up whether that bank already holds the wanted row. The result is one of three cases: a row hit, a bank that must be activated, or a bank that is open on another row and must be precharged before it is activated. The block reports this case, together with the bank, row and column, as a one-cycle registered response under a valid/ready handshake.

Rows are never closed on the block's own initiative. An explicit all-banks-closed pulse, given after the scheduler has issued a precharge-all for refresh, is the only thing that closes them. Every access also asks the scheduler to open the same row in the following bank, wrapping from the last bank to bank 0. A sequential stream that crosses into the next bank then finds it already open. The response carries this request alongside the main result.

Each bank keeps a short history register: an open shifts in a 1, a close shifts in a 0, and the newest bit is the open flag. The speculative open is committed to the table one cycle after the access that caused it. Until then it is forwarded to lookups. If an access in that cycle needs a different row in the same bank, the access's row is the one that stays.

Top module: `sdram_bank_tracker`

## Requirements
- R1: The request address holds the column in its low COL_W bits (10 by default), the bank in the next BANK_W bits (3 by default, eight banks) and the row in the remaining ROW_W high bits (14 by default). The response echoes these three fields on rsp_col, rsp_bank and rsp_row.
- R2: An access to a bank that is open on the requested row gives rsp_hit=1, rsp_need_act=0 and rsp_need_pre=0.
- R3: An access to a closed bank gives rsp_need_act=1 and rsp_need_pre=0. An access to a bank that is open on a different row gives rsp_need_pre=1 and rsp_need_act=1, with rsp_hit=0 in both cases.
- R4: After an access that opens a bank, that bank holds the requested row. A later access to the same bank and row hits, whatever its column.
- R5: Every accepted access reports rsp_spec_bank = bank+1 modulo the bank count. rsp_spec_act is 1 unless that bank is already open on the same row, and rsp_spec_pre is 1 when that bank is open on another row. Afterwards the next bank holds the requested row.
- R6: An access accepted in the cycle straight after an access to the preceding bank sees the speculative open already in effect.
- R7: If a speculative open and an access that needs a different row target the same bank in the same cycle, the bank keeps the access's row.
- R8: req_ready equals (no response held or rsp_ready) and not refresh_close. The response appears in the cycle after acceptance and holds all its fields while rsp_valid=1 and rsp_ready=0.
- R9: A refresh_close pulse closes every bank and drops any pending speculative open. req_ready is 0 during the pulse.
- R10: After reset no response is valid and all banks are closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Access request accepted this cycle |
| req_addr | input | ROW_W+BANK_W+COL_W | Linear word address of the access |
| refresh_close | input | 1 | Pulse: all banks were precharged |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Scheduler takes the response |
| rsp_hit | output | 1 | Requested row already open |
| rsp_need_act | output | 1 | Activate needed before the column command |
| rsp_need_pre | output | 1 | Precharge needed before the activate |
| rsp_bank | output | BANK_W | Bank of the access |
| rsp_row | output | ROW_W | Row of the access |
| rsp_col | output | COL_W | Column of the access |
| rsp_spec_act | output | 1 | Speculative activate of the next bank requested |
| rsp_spec_pre | output | 1 | Speculative open needs a precharge first |
| rsp_spec_bank | output | BANK_W | Bank targeted by the speculative open |

## Verification
The bench looks hardest at the cycle straight after an access. It checks that a back-to-back access to the next bank sees the speculative open. A design that skipped the forwarding would report a needless activate there. It also checks that a required open to the bank whose speculative open is still pending keeps its own row. A design that let the speculative row win would miss on the later access. The wrap from the last bank to bank 0, a response held under backpressure while a second request waits, and a refresh close that must turn earlier hits into plain activates are also covered. A table that went stale or was not cleared would show a wrong hit in those cases.

// File: rtl/sbt_pkg.sv
package sbt_pkg;

    // Outcome of comparing a bank's open row against a wanted row
    typedef enum logic [1:0] {
        KIND_HIT  = 2'd0,   // bank open on the wanted row
        KIND_OPEN = 2'd1,   // bank closed: activate only
        KIND_SWAP = 2'd2    // bank open elsewhere: precharge then activate
    } sbt_kind_e;

endpackage

// File: rtl/sbt_addr_split.sv
module sbt_addr_split #(
    parameter int ROW_W  = 14,
    parameter int BANK_W = 3,
    parameter int COL_W  = 10,
    localparam int ADDR_W = ROW_W + BANK_W + COL_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [ROW_W-1:0]  row,
    output logic [BANK_W-1:0] bank,
    output logic [COL_W-1:0]  col,
    output logic [BANK_W-1:0] next_bank
);
    localparam int BANK_LO = COL_W;
    localparam int ROW_LO  = COL_W + BANK_W;

    assign col       = addr[COL_W-1:0];
    assign bank      = addr[BANK_LO +: BANK_W];
    assign row       = addr[ROW_LO +: ROW_W];
    // modulo wrap comes from the field width
    assign next_bank = bank + BANK_W'(1);
endmodule

// File: rtl/sbt_row_compare.sv
module sbt_row_compare
    import sbt_pkg::*;
#(
    parameter int ROW_W  = 14,
    parameter int BANK_W = 3,
    localparam int NBANK = 1 << BANK_W
) (
    input  logic [NBANK-1:0]            open_eff,
    input  logic [NBANK-1:0][ROW_W-1:0] row_eff,
    input  logic [BANK_W-1:0]           bank,
    input  logic [ROW_W-1:0]            row,
    output sbt_kind_e                   kind
);
    logic is_open;
    logic same_row;

    always_comb begin
        is_open  = open_eff[bank];
        same_row = (row_eff[bank] == row);
        if (!is_open)
            kind = KIND_OPEN;
        else if (same_row)
            kind = KIND_HIT;
        else
            kind = KIND_SWAP;
    end
endmodule

// File: rtl/sbt_bank_table.sv
module sbt_bank_table #(
    parameter int ROW_W  = 14,
    parameter int BANK_W = 3,
    parameter int HIST_W = 4,
    localparam int NBANK = 1 << BANK_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clear_all,
    // required open from an accepted access
    input  logic                        req_en,
    input  logic                        req_swap,
    input  logic [BANK_W-1:0]           req_bank,
    input  logic [ROW_W-1:0]            req_row,
    // speculative open, committed one cycle later
    input  logic                        spec_en,
    input  logic [BANK_W-1:0]           spec_bank,
    input  logic [ROW_W-1:0]            spec_row,
    // lookup view with the pending speculative open forwarded
    output logic [NBANK-1:0]            open_eff,
    output logic [NBANK-1:0][ROW_W-1:0] row_eff,
    // committed open flags
    output logic [NBANK-1:0]            open_q
);
    typedef struct packed {
        logic [NBANK-1:0][HIST_W-1:0] hist;
        logic [NBANK-1:0][ROW_W-1:0]  row;
        logic                         pend;
        logic [BANK_W-1:0]            pend_bank;
        logic [ROW_W-1:0]             pend_row;
    } tbl_t;

    tbl_t tbl_q, tbl_d;

    function automatic logic [HIST_W-1:0] push_open(input logic [HIST_W-1:0] h);
        return {h[HIST_W-2:0], 1'b1};
    endfunction

    function automatic logic [HIST_W-1:0] push_close(input logic [HIST_W-1:0] h);
        return {h[HIST_W-2:0], 1'b0};
    endfunction

    function automatic logic [HIST_W-1:0] push_swap(input logic [HIST_W-1:0] h);
        return {h[HIST_W-3:0], 2'b01};
    endfunction

    logic spec_blocked;

    always_comb begin
        tbl_d        = tbl_q;
        spec_blocked = req_en && (req_bank == tbl_q.pend_bank);

        if (clear_all) begin
            for (int i = 0; i < NBANK; i++)
                tbl_d.hist[i] = push_close(tbl_q.hist[i]);
            tbl_d.pend = 1'b0;
        end else begin
            // commit last cycle's speculative open unless a required open wins
            if (tbl_q.pend && !spec_blocked) begin
                if (!tbl_q.hist[tbl_q.pend_bank][0])
                    tbl_d.hist[tbl_q.pend_bank] = push_open(tbl_q.hist[tbl_q.pend_bank]);
                else if (tbl_q.row[tbl_q.pend_bank] != tbl_q.pend_row)
                    tbl_d.hist[tbl_q.pend_bank] = push_swap(tbl_q.hist[tbl_q.pend_bank]);
                tbl_d.row[tbl_q.pend_bank] = tbl_q.pend_row;
            end
            if (req_en) begin
                tbl_d.hist[req_bank] = req_swap ? push_swap(tbl_q.hist[req_bank])
                                                : push_open(tbl_q.hist[req_bank]);
                tbl_d.row[req_bank]  = req_row;
            end
            tbl_d.pend      = spec_en;
            tbl_d.pend_bank = spec_bank;
            tbl_d.pend_row  = spec_row;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    for (genvar g = 0; g < NBANK; g++) begin : g_view
        logic pend_here;
        assign pend_here   = tbl_q.pend && (tbl_q.pend_bank == BANK_W'(g));
        assign open_q[g]   = tbl_q.hist[g][0];
        assign open_eff[g] = tbl_q.hist[g][0] | pend_here;
        assign row_eff[g]  = pend_here ? tbl_q.pend_row : tbl_q.row[g];
    end
endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
    import sbt_pkg::*;
#(
    parameter int ROW_W  = 14,
    parameter int BANK_W = 3,
    parameter int COL_W  = 10,
    parameter int HIST_W = 4,
    localparam int ADDR_W = ROW_W + BANK_W + COL_W,
    localparam int NBANK  = 1 << BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              refresh_close,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic              rsp_hit,
    output logic              rsp_need_act,
    output logic              rsp_need_pre,
    output logic [BANK_W-1:0] rsp_bank,
    output logic [ROW_W-1:0]  rsp_row,
    output logic [COL_W-1:0]  rsp_col,
    output logic              rsp_spec_act,
    output logic              rsp_spec_pre,
    output logic [BANK_W-1:0] rsp_spec_bank
);
    typedef struct packed {
        logic              valid;
        logic              hit;
        logic              act;
        logic              pre;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic              spec_act;
        logic              spec_pre;
        logic [BANK_W-1:0] spec_bank;
    } rsp_t;

    rsp_t rsp_q, rsp_d;

    logic [ROW_W-1:0]            a_row;
    logic [BANK_W-1:0]           a_bank;
    logic [COL_W-1:0]            a_col;
    logic [BANK_W-1:0]           a_next;
    logic [NBANK-1:0]            open_eff;
    logic [NBANK-1:0][ROW_W-1:0] row_eff;
    logic [NBANK-1:0]            bank_open_q;
    sbt_kind_e                   kind_req;
    sbt_kind_e                   kind_next;
    logic                        accept;

    sbt_addr_split #(.ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W)) u_split (
        .addr      (req_addr),
        .row       (a_row),
        .bank      (a_bank),
        .col       (a_col),
        .next_bank (a_next)
    );

    sbt_row_compare #(.ROW_W(ROW_W), .BANK_W(BANK_W)) u_cmp_req (
        .open_eff (open_eff),
        .row_eff  (row_eff),
        .bank     (a_bank),
        .row      (a_row),
        .kind     (kind_req)
    );

    sbt_row_compare #(.ROW_W(ROW_W), .BANK_W(BANK_W)) u_cmp_next (
        .open_eff (open_eff),
        .row_eff  (row_eff),
        .bank     (a_next),
        .row      (a_row),
        .kind     (kind_next)
    );

    sbt_bank_table #(.ROW_W(ROW_W), .BANK_W(BANK_W), .HIST_W(HIST_W)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_all (refresh_close),
        .req_en    (accept && (kind_req != KIND_HIT)),
        .req_swap  (kind_req == KIND_SWAP),
        .req_bank  (a_bank),
        .req_row   (a_row),
        .spec_en   (accept && (kind_next != KIND_HIT)),
        .spec_bank (a_next),
        .spec_row  (a_row),
        .open_eff  (open_eff),
        .row_eff   (row_eff),
        .open_q    (bank_open_q)
    );

    assign req_ready = (!rsp_q.valid || rsp_ready) && !refresh_close;
    assign accept    = req_valid && req_ready;

    always_comb begin
        rsp_d = rsp_q;
        if (rsp_q.valid && rsp_ready)
            rsp_d.valid = 1'b0;
        if (accept) begin
            rsp_d.valid     = 1'b1;
            rsp_d.hit       = (kind_req == KIND_HIT);
            rsp_d.act       = (kind_req != KIND_HIT);
            rsp_d.pre       = (kind_req == KIND_SWAP);
            rsp_d.bank      = a_bank;
            rsp_d.row       = a_row;
            rsp_d.col       = a_col;
            rsp_d.spec_act  = (kind_next != KIND_HIT);
            rsp_d.spec_pre  = (kind_next == KIND_SWAP);
            rsp_d.spec_bank = a_next;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid     = rsp_q.valid;
    assign rsp_hit       = rsp_q.hit;
    assign rsp_need_act  = rsp_q.act;
    assign rsp_need_pre  = rsp_q.pre;
    assign rsp_bank      = rsp_q.bank;
    assign rsp_row       = rsp_q.row;
    assign rsp_col       = rsp_q.col;
    assign rsp_spec_act  = rsp_q.spec_act;
    assign rsp_spec_pre  = rsp_q.spec_pre;
    assign rsp_spec_bank = rsp_q.spec_bank;
endmodule

// File: rtl/sbt_checker.sv
module sbt_checker #(
    parameter int ROW_W  = 14,
    parameter int BANK_W = 3,
    parameter int COL_W  = 10,
    localparam int ADDR_W = ROW_W + BANK_W + COL_W,
    localparam int NBANK  = 1 << BANK_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              refresh_close,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic              rsp_hit,
    input logic              rsp_need_act,
    input logic              rsp_need_pre,
    input logic [BANK_W-1:0] rsp_bank,
    input logic [ROW_W-1:0]  rsp_row,
    input logic [COL_W-1:0]  rsp_col,
    input logic              rsp_spec_act,
    input logic [BANK_W-1:0] rsp_spec_bank,
    input logic [NBANK-1:0]  open_vec
);
    logic [BANK_W-1:0] in_bank;
    assign in_bank = req_addr[COL_W +: BANK_W];

    // R3: a precharge is always followed by an activate
    a_r3_pre_needs_act: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_need_pre |-> rsp_need_act && !rsp_hit);

    // R4: an accepted access leaves its bank open
    a_r4_bank_open_after: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> open_vec[$past(in_bank)]);

    // R5: speculative target is the following bank
    a_r5_spec_neighbour: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_spec_act |-> rsp_spec_bank == rsp_bank + BANK_W'(1));

    // R8: a held response keeps every field
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_bank) && $stable(rsp_row)
            && $stable(rsp_col) && $stable(rsp_hit) && $stable(rsp_need_act));

    // R9: refresh close blocks intake and empties the table
    a_r9_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_close |-> !req_ready);

    a_r9_all_closed: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_close |=> open_vec == '0);
endmodule

bind sdram_bank_tracker sbt_checker #(.ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_addr      (req_addr),
    .refresh_close (refresh_close),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_hit       (rsp_hit),
    .rsp_need_act  (rsp_need_act),
    .rsp_need_pre  (rsp_need_pre),
    .rsp_bank      (rsp_bank),
    .rsp_row       (rsp_row),
    .rsp_col       (rsp_col),
    .rsp_spec_act  (rsp_spec_act),
    .rsp_spec_bank (rsp_spec_bank),
    .open_vec      (bank_open_q)
);

// File: tb/sdram_bank_tracker_test.sv
module sdram_bank_tracker_test;
    localparam int CLK_PERIOD = 10;
    localparam int ROW_W  = 14;
    localparam int BANK_W = 3;
    localparam int COL_W  = 10;
    localparam int NBANK  = 1 << BANK_W;
    localparam int ADDR_W = ROW_W + BANK_W + COL_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              refresh_close = 1'b0;
    logic              rsp_valid;
    logic              rsp_ready = 1'b1;
    logic              rsp_hit, rsp_need_act, rsp_need_pre;
    logic [BANK_W-1:0] rsp_bank;
    logic [ROW_W-1:0]  rsp_row;
    logic [COL_W-1:0]  rsp_col;
    logic              rsp_spec_act, rsp_spec_pre;
    logic [BANK_W-1:0] rsp_spec_bank;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // reference view: opens take effect at once
    bit               m_open [NBANK];
    logic [ROW_W-1:0] m_row  [NBANK];

    typedef struct {
        logic hit, act, pre, sact, spre;
        logic [BANK_W-1:0] sbank;
    } exp_t;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_bank_tracker #(.ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .refresh_close(refresh_close), .rsp_valid(rsp_valid),
        .rsp_ready(rsp_ready), .rsp_hit(rsp_hit), .rsp_need_act(rsp_need_act),
        .rsp_need_pre(rsp_need_pre), .rsp_bank(rsp_bank), .rsp_row(rsp_row),
        .rsp_col(rsp_col), .rsp_spec_act(rsp_spec_act), .rsp_spec_pre(rsp_spec_pre),
        .rsp_spec_bank(rsp_spec_bank)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic predict(input logic [ROW_W-1:0] row, input logic [BANK_W-1:0] bank,
                           output exp_t e);
        logic [BANK_W-1:0] nb;
        nb      = bank + BANK_W'(1);
        e.hit   = m_open[bank] && m_row[bank] == row;
        e.act   = !e.hit;
        e.pre   = m_open[bank] && m_row[bank] != row;
        e.sact  = !(m_open[nb] && m_row[nb] == row);
        e.spre  = m_open[nb] && m_row[nb] != row;
        e.sbank = nb;
        m_open[bank] = 1'b1; m_row[bank] = row;
        m_open[nb]   = 1'b1; m_row[nb]   = row;
    endtask

    task automatic check_rsp(input string req, input logic [ROW_W-1:0] row,
                             input logic [BANK_W-1:0] bank, input logic [COL_W-1:0] col,
                             input exp_t e);
        chk("R8", "rsp_valid", rsp_valid, 1);
        chk("R1", "rsp_row", rsp_row, row);
        chk("R1", "rsp_bank", rsp_bank, bank);
        chk("R1", "rsp_col", rsp_col, col);
        chk(req, "rsp_hit", rsp_hit, e.hit);
        chk(req, "rsp_need_act", rsp_need_act, e.act);
        chk(req, "rsp_need_pre", rsp_need_pre, e.pre);
        chk("R5", "rsp_spec_act", rsp_spec_act, e.sact);
        chk("R5", "rsp_spec_pre", rsp_spec_pre, e.spre);
        chk("R5", "rsp_spec_bank", rsp_spec_bank, e.sbank);
    endtask

    // one accepted access; consecutive calls are back to back
    task automatic access(input string req, input logic [ROW_W-1:0] row,
                          input logic [BANK_W-1:0] bank, input logic [COL_W-1:0] col);
        exp_t e;
        predict(row, bank, e);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = {row, bank, col};
        @(posedge clk); #1;
        req_valid = 1'b0;
        check_rsp(req, row, bank, col, e);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_clear();
        @(negedge clk);
        refresh_close = 1'b1;
        #1 chk("R9", "req_ready during close", req_ready, 0);
        @(negedge clk);
        refresh_close = 1'b0;
        for (int i = 0; i < NBANK; i++) m_open[i] = 1'b0;
    endtask

    task automatic t_reset();
        for (int i = 0; i < NBANK; i++) begin m_open[i] = 1'b0; m_row[i] = '0; end
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 chk("R10", "rsp_valid after reset", rsp_valid, 0);
        chk("R8", "req_ready after reset", req_ready, 1);
        @(negedge clk) rst_n = 1'b1;
        access("R10", 14'h0123, 3'd4, 10'h000);   // must be a plain activate
    endtask

    task automatic t_open_and_hit();
        idle(2);
        access("R3", 14'h0005, 3'd2, 10'h007);    // closed bank
        idle(2);
        access("R2", 14'h0005, 3'd2, 10'h3ff);    // same row, other column
        access("R4", 14'h0005, 3'd2, 10'h155);
    endtask

    task automatic t_spec_settled();
        idle(3);
        access("R5", 14'h0005, 3'd3, 10'h010);    // opened earlier by lookahead
    endtask

    task automatic t_spec_forward();
        do_clear();
        access("R3", 14'h0a0a, 3'd5, 10'h001);
        access("R6", 14'h0a0a, 3'd6, 10'h002);    // next cycle, forwarded hit
        access("R6", 14'h0a0a, 3'd7, 10'h003);
    endtask

    task automatic t_wrap_and_miss();
        idle(2);
        access("R5", 14'h0a0a, 3'd0, 10'h004);    // bank 0 opened by wrap from 7
        idle(1);
        access("R3", 14'h1fff, 3'd0, 10'h005);    // row miss: precharge + activate
        idle(1);
        access("R5", 14'h1fff, 3'd7, 10'h006);    // lookahead wraps to bank 0 hit
    endtask

    task automatic t_priority();
        do_clear();
        access("R3", 14'h0111, 3'd0, 10'h020);
        access("R7", 14'h0222, 3'd1, 10'h021);    // collides with pending lookahead
        idle(3);
        access("R7", 14'h0222, 3'd1, 10'h022);    // required row must have stayed
    endtask

    task automatic t_stall();
        exp_t ea, eb;
        idle(2);
        predict(14'h0020, 3'd3, ea);
        predict(14'h0021, 3'd5, eb);
        @(negedge clk);
        rsp_ready = 1'b0;
        req_valid = 1'b1;
        req_addr  = {14'h0020, 3'd3, 10'h0aa};
        @(posedge clk); #1;
        req_addr  = {14'h0021, 3'd5, 10'h0bb};
        chk("R8", "req_ready while held", req_ready, 0);
        check_rsp("R8", 14'h0020, 3'd3, 10'h0aa, ea);
        @(posedge clk); #1;
        check_rsp("R8", 14'h0020, 3'd3, 10'h0aa, ea);
        @(negedge clk);
        rsp_ready = 1'b1;
        @(posedge clk); #1;
        req_valid = 1'b0;
        check_rsp("R8", 14'h0021, 3'd5, 10'h0bb, eb);
    endtask

    task automatic t_refresh();
        idle(2);
        do_clear();
        access("R9", 14'h0021, 3'd5, 10'h0bb);    // was a hit before the close
        idle(2);
        @(posedge clk); #1;
        chk("R8", "rsp_valid drops after take", rsp_valid, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_open_and_hit();
        t_spec_settled();
        t_spec_forward();
        t_wrap_and_miss();
        t_priority();
        t_stall();
        t_refresh();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule